// File: doc/BRIEF.md
# Grouped Pin Change Interrupt Controller

This block watches sixteen general-purpose inputs, arranged as two groups of eight, and turns any level change on a selected pin into a sticky per-group flag. Each group can raise its own interrupt request line toward an interrupt controller. Software selects the watched pins with one mask byte per group, enables each group's request with a bit in a control byte, and reads or clears the flags through a byte-wide register bus. A global interrupt-enable input gates both requests, and a per-group acknowledge input clears a flag when its vector is taken.

Each pin passes through a two-flop synchronizer. A change is found by comparing the synchronized level with the level sampled one cycle earlier. Each group's flag is held in a two-state machine: `FLG_CLEAR` (no event pending) and `FLG_PENDING` (event pending). The transition *detect* (`FLG_CLEAR` to `FLG_PENDING`) is taken when any masked-in pin changes. The transition *release* (`FLG_PENDING` to `FLG_CLEAR`) is taken on a write-one or an acknowledge, but only when no change arrives in that same cycle. In every other case a state holds.

Register map on the byte bus: flag register at 0x3B, control register at 0x68, mask for pins 7..0 at 0x6B, mask for pins 15..8 at 0x6C. Any other address reads zero and ignores writes.

Top module: `pinchg_irq_top`

## Requirements
- R1: Pins 7..0 form group 0 and pins 15..8 form group 1. A change on a pin affects only the flag of its own group.
- R2: Bit i of the mask register at 0x6B selects pin i, and bit i of the mask register at 0x6C selects pin 8+i. A change on a pin whose mask bit is zero sets no flag.
- R3: A rising or a falling change on a masked-in pin sets its group's flag. The flag register at 0x3B holds group 0's flag in bit 0 and group 1's flag in bit 1.
- R4: `irq[g]` is one exactly when flag g, bit g of the control register at 0x68, and `gie` are all one.
- R5: Writing the flag register clears each flag whose data bit is one. A zero data bit leaves that flag unchanged.
- R6: A one-cycle pulse on `ack[g]` clears flag g.
- R7: When a new change and a clear (write-one or acknowledge) reach a group in the same cycle, the flag ends up set.
- R8: Writing a mask register never sets a flag by itself, even when pins changed earlier while they were masked out.
- R9: Flags are set whatever the values of the control register and `gie`.
- R10: Bits 7..2 of the flag register and of the control register always read zero. The mask registers read back as written.
- R11: After reset, all four registers read 0x00 and both `irq` bits are zero.
- R12: A pin change driven between two clock edges appears in the flag register after the third rising edge that follows, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins | input | 16 | Asynchronous general-purpose inputs being watched |
| gie | input | 1 | Global interrupt enable |
| ack | input | 2 | Per-group vector-taken acknowledge, one-cycle pulse |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe for the register at bus_addr |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 2 | Per-group interrupt request |

## Verification
The two group functions that can fall in the same cycle are the *detect* transition and the *release* transition. The bench provokes this by toggling a masked-in pin at a known falling edge. It then waits until the synchronized edge is one cycle from the flag register and holds a write-one, or an acknowledge, so that both act on the same rising edge. The flag must still read one afterwards. As a control case, the same clear is issued with no change pending, and the flag must then drop to zero.

// File: rtl/pinchg_pkg.sv
package pinchg_pkg;
    typedef enum logic {
        FLG_CLEAR   = 1'b0,
        FLG_PENDING = 1'b1
    } flag_state_e;
endpackage

// File: rtl/pinchg_sync.sv
module pinchg_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= '0;
                end else if (s == 0) begin
                    chain_q[s] <= async_in;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pinchg_group.sv
module pinchg_group
    import pinchg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_s,
    input  logic [WIDTH-1:0] mask,
    input  logic             clr_wr,
    input  logic             ack,
    output logic             flag
);
    flag_state_e state_q, state_d;
    logic [WIDTH-1:0] prev_q;
    logic             change;
    logic             clear;

    // The previous level is tracked whatever the mask, so that enabling
    // a pin later cannot make an old change look new.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_s;
    end

    assign change = |((pin_s ^ prev_q) & mask);
    assign clear  = clr_wr | ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR:   if (change)          state_d = FLG_PENDING;
            FLG_PENDING: if (clear && !change) state_d = FLG_CLEAR;
            default:                          state_d = FLG_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q == FLG_PENDING);
    end

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        change |=> flag);
    a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !change) |=> !flag);
    a_r6_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !change) |=> !flag);
    a_r3_rise_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(change));
endmodule

// File: rtl/pinchg_irq_top.sv
module pinchg_irq_top #(
    parameter int          NUM_GROUPS  = 2,
    parameter int          GROUP_WIDTH = 8,
    parameter int          SYNC_STAGES = 2,
    parameter int          DATA_W      = 8,
    parameter int          ADDR_W      = 8,
    parameter logic [7:0]  ADDR_FLAG   = 8'h3B,
    parameter logic [7:0]  ADDR_CTRL   = 8'h68,
    parameter logic [7:0]  ADDR_MASK0  = 8'h6B
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_GROUPS*GROUP_WIDTH-1:0] pins,
    input  logic                              gie,
    input  logic [NUM_GROUPS-1:0]             ack,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic                              bus_wr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [DATA_W-1:0]                 bus_rdata,
    output logic [NUM_GROUPS-1:0]             irq
);
    localparam int PIN_W = NUM_GROUPS * GROUP_WIDTH;

    logic [PIN_W-1:0]       pin_s;
    logic [GROUP_WIDTH-1:0] mask_q [NUM_GROUPS];
    logic [NUM_GROUPS-1:0]  en_q;
    logic [NUM_GROUPS-1:0]  flag;
    logic                   flag_wr;

    assign flag_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_FLAG));

    pinchg_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins),
        .sync_out (pin_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= '0;
        else if (bus_wr && bus_addr == ADDR_W'(ADDR_CTRL))
            en_q <= bus_wdata[NUM_GROUPS-1:0];
    end

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            localparam logic [ADDR_W-1:0] MADDR = ADDR_W'(ADDR_MASK0) + ADDR_W'(g);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mask_q[g] <= '0;
                else if (bus_wr && bus_addr == MADDR)
                    mask_q[g] <= bus_wdata[GROUP_WIDTH-1:0];
            end

            pinchg_group #(
                .WIDTH (GROUP_WIDTH)
            ) u_group (
                .clk    (clk),
                .rst_n  (rst_n),
                .pin_s  (pin_s[g*GROUP_WIDTH +: GROUP_WIDTH]),
                .mask   (mask_q[g]),
                .clr_wr (flag_wr && bus_wdata[g]),
                .ack    (ack[g]),
                .flag   (flag[g])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADDR_FLAG))
            bus_rdata[NUM_GROUPS-1:0] = flag;
        if (bus_addr == ADDR_W'(ADDR_CTRL))
            bus_rdata[NUM_GROUPS-1:0] = en_q;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (bus_addr == ADDR_W'(ADDR_MASK0) + ADDR_W'(g))
                bus_rdata[GROUP_WIDTH-1:0] = mask_q[g];
        end
    end

    assign irq = flag & en_q & {NUM_GROUPS{gie}};

    a_r4_gie_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> (irq == '0));
    a_r10_flag_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(ADDR_FLAG)) |-> (bus_rdata[DATA_W-1:NUM_GROUPS] == '0));
    a_r6_ack_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[0] && $stable(pin_s)) |=> !irq[0]);
endmodule

// File: tb/test_pinchg_irq_top.sv
module test_pinchg_irq_top;
    localparam logic [7:0] A_FLAG = 8'h3B, A_CTRL = 8'h68, A_M0 = 8'h6B, A_M1 = 8'h6C;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] pins = '0;
    logic        gie = 0;
    logic [1:0]  ack = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pinchg_irq_top i_pinchg_irq_top (
        .clk(clk), .rst_n(rst_n), .pins(pins), .gie(gie), .ack(ack),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [1:0] exp_flags(logic [15:0] tog, logic [7:0] m0, logic [7:0] m1);
        return {|(tog[15:8] & m1), |(tog[7:0] & m0)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic toggle(logic [15:0] t);
        @(negedge clk);
        pins = pins ^ t;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R11 reset state
        rd(A_FLAG, d); check("R11 flag", d, 0);
        rd(A_CTRL, d); check("R11 ctrl", d, 0);
        rd(A_M0, d);   check("R11 mask0", d, 0);
        rd(A_M1, d);   check("R11 mask1", d, 0);
        check("R11 irq", irq, 0);

        // R10 reserved bits
        wr(A_CTRL, 8'hFF); rd(A_CTRL, d); check("R10 ctrl readback", d, 8'h03);
        wr(A_M1, 8'hA5);   rd(A_M1, d);   check("R10 mask1 readback", d, 8'hA5);

        // R8 masked change then mask write sets nothing
        wr(A_M0, 8'h00); wr(A_M1, 8'h00);
        toggle(16'h0F0F); settle();
        wr(A_M0, 8'hFF); wr(A_M1, 8'hFF); settle();
        rd(A_FLAG, d); check("R8 mask write no flag", d, 0);

        // R12 latency
        bus_addr = A_FLAG;
        toggle(16'h0001);
        @(negedge clk); @(negedge clk); #1 check("R12 after two edges", bus_rdata, 0);
        @(negedge clk); #1 check("R12 after three edges", bus_rdata, 8'h01);

        // R3 falling edge also counts
        wr(A_FLAG, 8'h03); toggle(16'h0001); settle();
        rd(A_FLAG, d); check("R3 falling change", d, 8'h01);

        // R1 group separation
        wr(A_M1, 8'h00); wr(A_FLAG, 8'h03);
        toggle(16'h0100); settle();
        rd(A_FLAG, d); check("R1 pin8 masked in group1 only", d, 0);
        wr(A_M1, 8'h01); toggle(16'h0100); settle();
        rd(A_FLAG, d); check("R1 pin8 sets group1 flag", d, 8'h02);
        check("R10 flag reserved bits", d[7:2], 0);

        // R5 write one clears, zero keeps
        wr(A_M1, 8'hFF); toggle(16'h0101); settle();
        rd(A_FLAG, d); check("R5 both set", d, 8'h03);
        wr(A_FLAG, 8'h01); rd(A_FLAG, d); check("R5 write one clears bit0", d, 8'h02);
        wr(A_FLAG, 8'h00); rd(A_FLAG, d); check("R5 write zero keeps", d, 8'h02);

        // R6 acknowledge
        @(negedge clk); ack = 2'b10; @(negedge clk); ack = 2'b00;
        rd(A_FLAG, d); check("R6 ack clears flag1", d, 0);

        // R9 flags set while disabled, R4 irq gating
        gie = 0; wr(A_CTRL, 8'h00);
        toggle(16'h0202); settle();
        rd(A_FLAG, d); check("R9 flags set while disabled", d, 8'h03);
        check("R4 irq off while disabled", irq, 0);
        wr(A_CTRL, 8'h01); check("R4 gie low blocks", irq, 0);
        gie = 1; #1 check("R4 irq group0 only", irq, 2'b01);

        // R7 write-one clear collides with a change
        wr(A_FLAG, 8'h03); toggle(16'h0004); settle();
        pins = pins ^ 16'h0008;                  // driven at a falling edge
        @(negedge clk); @(negedge clk);
        bus_addr = A_FLAG; bus_wdata = 8'h01; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
        rd(A_FLAG, d); check("R7 set wins over write clear", d[0], 1);
        wr(A_FLAG, 8'h01); rd(A_FLAG, d); check("R5 control clear no change", d[0], 0);

        // R7 acknowledge collides with a change
        toggle(16'h0400); settle();
        @(negedge clk); pins = pins ^ 16'h0800;
        @(negedge clk); @(negedge clk);
        ack = 2'b10;
        @(negedge clk); ack = 2'b00;
        rd(A_FLAG, d); check("R7 set wins over ack", d[1], 1);

        // Random trials, R2 R3 R4
        for (int i = 0; i < 60; i++) begin
            logic [7:0]  m0, m1, en;
            logic [15:0] t;
            logic [1:0]  e;
            m0 = 8'($urandom); m1 = 8'($urandom); en = 8'($urandom);
            t = 16'($urandom);
            if (i % 4 == 0) t = 16'(1) << ($urandom % 16);
            wr(A_M0, m0); wr(A_M1, m1); wr(A_CTRL, en);
            gie = 1'($urandom);
            settle();
            wr(A_FLAG, 8'h03);
            toggle(t); settle();
            e = exp_flags(t, m0, m1);
            rd(A_FLAG, d);
            check("R2 R3 random flags", d, {6'b0, e});
            check("R4 random irq", irq, e & en[1:0] & {2{gie}});
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule